// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Clear

This block is a watchdog counter. While a prescaler tick enable is high, it counts up by one each cycle. Software must service it before the counter rolls over. If the counter rolls over, the block raises a time-out flag and gives a single-cycle reset request to the system reset logic. The counter then starts again from zero.

An instruction decoder services the watchdog through three strobes: a single-step clear and two pre-clear strobes, A and B. A mode input selects which of these are honoured:

- **Single-step mode:** the single-step clear is honoured.
- **Two-step mode:** only the A/B pair is honoured. The watchdog clears only when one pre-clear follows the other in alternation, so a stray repeated strobe cannot keep the watchdog alive.

Every effective clear zeroes the counter, the time-out flag and the power-down flag. A sleep-entry strobe sets the power-down flag and clears the time-out flag.

Top module: `wdog_twostep_top`

## Requirements
- R1: In single-step mode (`two_step_mode`=0), `clr_single` sets `count`, `to_flag` and `pd_flag` to 0 on the next cycle. This clear takes priority over a coinciding `tick_en`, including one that would roll the counter over, and in that case no reset request is produced.
- R2: In two-step mode (`two_step_mode`=1), the watchdog clears when the opposite pre-clear strobe arrives after an earlier one. The order may be A then B or B then A, and idle cycles may lie between the two. The clear zeroes `count`, `to_flag` and `pd_flag`, and the record of the last pre-clear returns to "none".
- R3: In two-step mode, repeating the same pre-clear strobe with no opposite strobe in between has no effect on `count` or the flags.
- R4: In two-step mode, a cycle with `preclr_a` and `preclr_b` both high is ignored. It neither clears the watchdog nor changes the record of the last pre-clear.
- R5: Two-step mode ignores `clr_single`, and single-step mode ignores `preclr_a` and `preclr_b`.
- R6: `count` increments by one only in cycles where `tick_en` is 1, and holds otherwise.
- R7: When `count` is all ones and a tick arrives, on the next cycle `count` is 0, `to_flag` is 1 and `rst_req` is 1. `rst_req` stays high for exactly that one cycle, and `to_flag` stays set until a clear or a sleep.
- R8: `sleep_req` sets `pd_flag` to 1 and `to_flag` to 0 on the next cycle. A clear in the same cycle acts first, so `pd_flag` still ends at 1 and the counter is zeroed.
- R9: While `rst_n` is low at a clock edge, the next state is `count`=0, `to_flag`=0, `pd_flag`=0 and `rst_req`=0. The record of the last pre-clear is also forgotten, so a single pre-clear after reset does not clear.
- R10: Any cycle in single-step mode forgets the last pre-clear. After a return to two-step mode, the first strobe only arms and does not clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaler tick; count advances when high |
| two_step_mode | input | 1 | 1 = alternating A/B clear, 0 = single-step clear |
| clr_single | input | 1 | Single-step clear strobe |
| preclr_a | input | 1 | Pre-clear strobe A |
| preclr_b | input | 1 | Pre-clear strobe B |
| sleep_req | input | 1 | Sleep-entry strobe |
| count | output | CNT_W | Current watchdog count |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| rst_req | output | 1 | One-cycle reset request on roll-over |

## Verification
The record of the last pre-clear is the only hidden state. An error in it shows at the ports on the next pre-clear strobe:

- a spurious clear zeroes `count` and the flags one cycle after a strobe that should only arm;
- a missed clear leaves `count` still counting one cycle after the opposite strobe.

A wrong counter or flag register shows one cycle later in `count`, `to_flag` or `pd_flag`. An error in roll-over handling shows in the `rst_req` pulse width, or in a missing `to_flag`, in the cycle after the tick at all ones.

// File: rtl/wdog_pkg.sv
// Package: shared types for the two-step watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdog_pkg;
    // Records which pre-clear strobe was seen last in two-step mode.
    typedef enum logic [1:0] {
        ARM_NONE = 2'b00,
        ARM_A    = 2'b01,
        ARM_B    = 2'b10
    } arm_e;
endpackage

// File: rtl/wdog_clear_qual.sv
// Module: wdog_clear_qual
// Decides whether this cycle carries an effective clear. In single-step
// mode the single strobe passes through. In two-step mode a pre-clear
// counts only when the other one was the last seen. Assumes strobes are
// synchronous one-cycle pulses from the decoder.
module wdog_clear_qual
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic two_step_mode,
    input  logic clr_single,
    input  logic preclr_a,
    input  logic preclr_b,
    output logic clr_eff
);
    arm_e arm_q;
    arm_e arm_d;
    logic a_only;
    logic b_only;

    // Qualify strobes: simultaneous A and B are treated as neither.
    always_comb begin
        a_only = preclr_a & ~preclr_b;
        b_only = preclr_b & ~preclr_a;
    end

    // Decide if a clear takes effect this cycle.
    always_comb begin
        if (two_step_mode) begin
            clr_eff = (a_only && (arm_q == ARM_B)) ||
                      (b_only && (arm_q == ARM_A));
        end else begin
            clr_eff = clr_single;
        end
    end

    // Next value of the alternation record.
    always_comb begin
        arm_d = arm_q;
        if (!two_step_mode) begin
            arm_d = ARM_NONE;
        end else if (clr_eff) begin
            arm_d = ARM_NONE;
        end else if (a_only) begin
            arm_d = ARM_A;
        end else if (b_only) begin
            arm_d = ARM_B;
        end
    end

    // Alternation record register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= ARM_NONE;
        end else begin
            arm_q <= arm_d;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// Up-counter that advances on a tick and wraps at all ones. A clear has
// priority over a tick. Assumes CNT_W >= 2.
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Roll-over event: a tick at all ones that no clear overrides.
    always_comb begin
        wrap = tick && !clr && (cnt_q == CNT_MAX);
    end

    // Count register: clear, else advance on tick (wrap is natural).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/wdog_flags.sv
// Module: wdog_flags
// Holds the time-out and power-down flags and the reset request pulse.
// Within one cycle a clear acts before a sleep strobe. Assumes the wrap
// input is already suppressed by a clear.
module wdog_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sleep,
    input  logic wrap,
    output logic to_flag,
    output logic pd_flag,
    output logic rst_req
);
    logic to_q;
    logic pd_q;
    logic req_q;

    // Time-out flag: cleared by clear or sleep, set by roll-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q <= 1'b0;
        end else if (clr || sleep) begin
            to_q <= 1'b0;
        end else if (wrap) begin
            to_q <= 1'b1;
        end
    end

    // Power-down flag: sleep sets it (after clear), clear zeroes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q <= 1'b0;
        end else if (sleep) begin
            pd_q <= 1'b1;
        end else if (clr) begin
            pd_q <= 1'b0;
        end
    end

    // Reset request: one cycle per roll-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= wrap;
        end
    end

    assign to_flag = to_q;
    assign pd_flag = pd_q;
    assign rst_req = req_q;
endmodule

// File: rtl/wdog_twostep_top.sv
// Module: wdog_twostep_top
// Watchdog with a single-step or an alternating two-step clear. Wires
// clear qualification, the counter and the status flags together.
// Assumes all inputs are synchronous to clk.
module wdog_twostep_top #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             two_step_mode,
    input  logic             clr_single,
    input  logic             preclr_a,
    input  logic             preclr_b,
    input  logic             sleep_req,
    output logic [CNT_W-1:0] count,
    output logic             to_flag,
    output logic             pd_flag,
    output logic             rst_req
);
    logic clr_eff;
    logic wrap;

    wdog_clear_qual u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .two_step_mode (two_step_mode),
        .clr_single    (clr_single),
        .preclr_a      (preclr_a),
        .preclr_b      (preclr_b),
        .clr_eff       (clr_eff)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_eff),
        .tick  (tick_en),
        .count (count),
        .wrap  (wrap)
    );

    wdog_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_eff),
        .sleep   (sleep_req),
        .wrap    (wrap),
        .to_flag (to_flag),
        .pd_flag (pd_flag),
        .rst_req (rst_req)
    );
endmodule

// File: rtl/wdog_checker.sv
// Module: wdog_checker
// Temporal checks on the watchdog ports and the internal clear decision.
// Bound into wdog_twostep_top below.
module wdog_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             two_step_mode,
    input logic             clr_single,
    input logic             preclr_a,
    input logic             preclr_b,
    input logic             sleep_req,
    input logic [CNT_W-1:0] count,
    input logic             to_flag,
    input logic             pd_flag,
    input logic             rst_req,
    input logic             clr_eff
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_single_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_step_mode && clr_single) |=> (count == '0 && !to_flag && !rst_req));

    assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_eff && !sleep_req) |=> (count == '0 && !to_flag && !pd_flag));

    assert_repeat_no_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (two_step_mode && preclr_a && !preclr_b &&
         $past(rst_n && two_step_mode && preclr_a && !preclr_b)) |-> !clr_eff);

    assert_both_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (two_step_mode && preclr_a && preclr_b) |-> !clr_eff);

    assert_single_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (two_step_mode && clr_single && !preclr_a && !preclr_b) |-> !clr_eff);

    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !clr_eff) |=> $stable(count));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !clr_eff && !sleep_req && count == CNT_MAX) |=>
        (rst_req && to_flag && count == '0));

    assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (pd_flag && !to_flag));
endmodule

bind wdog_twostep_top wdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .two_step_mode (two_step_mode),
    .clr_single    (clr_single),
    .preclr_a      (preclr_a),
    .preclr_b      (preclr_b),
    .sleep_req     (sleep_req),
    .count         (count),
    .to_flag       (to_flag),
    .pd_flag       (pd_flag),
    .rst_req       (rst_req),
    .clr_eff       (clr_eff)
);

// File: tb/sim_wdog_twostep_top.sv
// Bench for wdog_twostep_top with a 4-bit counter: a vector table walked
// by one loop, then directed tests for roll-over, priority and reset.
module sim_wdog_twostep_top;
    localparam int W = 4;

    typedef struct packed {
        logic       mode;
        logic       single;
        logic       a;
        logic       b;
        logic       tick;
        logic       sleep;
        logic [3:0] cnt;
        logic       to;
        logic       pd;
        logic       rq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,1,0, 4'd1, 0,0,0, 4'd6},  // R6 tick
        '{0,0,0,0,1,0, 4'd2, 0,0,0, 4'd6},
        '{0,0,0,0,1,0, 4'd3, 0,0,0, 4'd6},
        '{0,0,0,0,0,0, 4'd3, 0,0,0, 4'd6},  // R6 hold without tick
        '{0,0,1,0,1,0, 4'd4, 0,0,0, 4'd5},  // R5 A ignored in single mode
        '{0,0,0,0,0,1, 4'd4, 0,1,0, 4'd8},  // R8 sleep
        '{0,1,0,0,0,0, 4'd0, 0,0,0, 4'd1},  // R1 single clear
        '{0,0,0,0,1,0, 4'd1, 0,0,0, 4'd6},
        '{0,1,0,0,0,1, 4'd0, 0,1,0, 4'd8},  // R8 clear + sleep
        '{0,0,0,0,1,0, 4'd1, 0,1,0, 4'd6},
        '{1,1,0,0,1,0, 4'd2, 0,1,0, 4'd5},  // R5 single ignored in two-step
        '{1,0,1,0,0,0, 4'd2, 0,1,0, 4'd3},  // arm A
        '{1,0,1,0,1,0, 4'd3, 0,1,0, 4'd3},  // R3 repeat A
        '{1,0,0,1,0,0, 4'd0, 0,0,0, 4'd2},  // R2 A then B
        '{1,0,0,0,1,0, 4'd1, 0,0,0, 4'd6},
        '{1,0,0,1,0,0, 4'd1, 0,0,0, 4'd3},  // arm B
        '{1,0,0,1,0,0, 4'd1, 0,0,0, 4'd3},  // R3 repeat B
        '{1,0,0,0,1,0, 4'd2, 0,0,0, 4'd2},
        '{1,0,1,0,0,0, 4'd0, 0,0,0, 4'd2},  // R2 B, gap, A
        '{1,0,0,0,1,0, 4'd1, 0,0,0, 4'd6},
        '{1,0,1,1,0,0, 4'd1, 0,0,0, 4'd4},  // R4 both at once
        '{1,0,0,1,0,0, 4'd1, 0,0,0, 4'd4},  // R4 record was still none
        '{0,0,0,0,1,0, 4'd2, 0,0,0, 4'd10}, // R10 leave two-step mode
        '{1,0,1,0,0,0, 4'd2, 0,0,0, 4'd10}, // R10 A only arms
        '{1,0,0,0,1,0, 4'd3, 0,0,0, 4'd6}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         two_step_mode = 1'b0;
    logic         clr_single = 1'b0;
    logic         preclr_a = 1'b0;
    logic         preclr_b = 1'b0;
    logic         sleep_req = 1'b0;
    logic [W-1:0] count;
    logic         to_flag;
    logic         pd_flag;
    logic         rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_twostep_top #(.CNT_W(W)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .two_step_mode (two_step_mode),
        .clr_single    (clr_single),
        .preclr_a      (preclr_a),
        .preclr_b      (preclr_b),
        .sleep_req     (sleep_req),
        .count         (count),
        .to_flag       (to_flag),
        .pd_flag       (pd_flag),
        .rst_req       (rst_req)
    );

    task automatic check(input string tag, input logic [3:0] ec,
                         input logic et, input logic ep, input logic er);
        n_chk++;
        if (count !== ec || to_flag !== et || pd_flag !== ep || rst_req !== er) begin
            n_fail++;
            $display("FAIL %s: got cnt=%0d to=%b pd=%b rq=%b, expected cnt=%0d to=%b pd=%b rq=%b",
                     tag, count, to_flag, pd_flag, rst_req, ec, et, ep, er);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; sample after the rise.
    task automatic cyc(input logic m, input logic s, input logic a,
                       input logic b, input logic t, input logic sl);
        @(negedge clk);
        two_step_mode = m; clr_single = s; preclr_a = a;
        preclr_b = b; tick_en = t; sleep_req = sl;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: bench timed out");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(0,0,0,0,1,0);
        cyc(0,0,0,0,1,0);
        check("R9 reset state", 4'd0, 0, 0, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].mode, VECS[i].single, VECS[i].a, VECS[i].b,
                VECS[i].tick, VECS[i].sleep);
            check($sformatf("R%0d vec%0d", VECS[i].req, i),
                  VECS[i].cnt, VECS[i].to, VECS[i].pd, VECS[i].rq);
        end

        // R7: roll-over from 3 up to 15, then wrap.
        for (int k = 0; k < 12; k++) cyc(0,0,0,0,1,0);
        check("R7 at max", 4'd15, 0, 0, 0);
        cyc(0,0,0,0,1,0);
        check("R7 wrap", 4'd0, 1, 0, 1);
        cyc(0,0,0,0,0,0);
        check("R7 pulse ends, TO held", 4'd0, 1, 0, 0);
        cyc(0,0,0,0,0,1);
        check("R8 sleep clears TO", 4'd0, 0, 1, 0);

        // R1: clear wins over a roll-over tick.
        for (int k = 0; k < 15; k++) cyc(0,0,0,0,1,0);
        check("R1 at max", 4'd15, 0, 1, 0);
        cyc(0,1,0,0,1,0);
        check("R1 clear beats wrap", 4'd0, 0, 0, 0);

        // R9: record forgotten over reset.
        cyc(1,0,1,0,0,0);
        rst_n = 1'b0;
        cyc(1,0,0,0,0,0);
        rst_n = 1'b1;
        cyc(1,0,0,0,1,0);
        cyc(1,0,0,0,1,0);
        check("R9 count after reset", 4'd2, 0, 0, 0);
        cyc(1,0,0,1,0,0);
        check("R9 B after reset only arms", 4'd2, 0, 0, 0);
        cyc(1,0,1,0,0,0);
        check("R2 A completes pair", 4'd0, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule